// File: doc/BRIEF.md
# I2C SCL high/low period generator

This block produces the serial clock of an I2C controller from the system clock. Four count registers hold the high and low durations: one pair for standard speed and one pair for fast speed. A speed field selects which pair is in use. The clock line is open-drain. The block only asserts a pull-low enable and never drives the line high.

When the block is enabled, it first holds the line released for a start-hold interval derived from the high count. It then pulls the line low for the low count plus one cycle. This interval starts in the cycle the block begins pulling, so any bus fall time is part of it. After release, the block waits until it samples the line high. A target that holds the line low therefore stretches the clock. Once the line is seen high, the block counts the high count plus three cycles and then pulls low again.

One-cycle strobes mark each falling and rising edge for the byte engine above the block. That engine handles shifting, acknowledge and arbitration.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset, `scl_oe_o`, `hold_o`, `fall_o` and `rise_o` are low. The count registers reset to these values: standard high 40, standard low 47, fast high 6, fast low 13.
- R2: While `en_i` is low, the line is released and no strobe or hold is shown. Dropping `en_i` releases the line in the next cycle, whatever phase the block is in.
- R3: Each low phase keeps `scl_oe_o` high for exactly L+1 consecutive cycles, where L is the effective low count. Counting starts in the first cycle of pulling low.
- R4: After a low phase, the block releases the line and waits for as long as `scl_i` is sampled low. In the cycle after `scl_i` is sampled high, it starts a high phase of H+3 cycles, where H is the effective high count. It then starts the next low phase.
- R5: A speed field `mode_i` equal to 4 selects the fast counts. Any other value, including 2, selects the standard counts. The selection is taken at the start of each phase.
- R6: On a rising `en_i`, `hold_o` is high for H+3 cycles with the line released. The first low phase follows directly.
- R7: A write with `cfg_we_i` high stores `cfg_data_i` into the register chosen by `cfg_sel_i`: 0 standard high, 1 standard low, 2 fast high, 3 fast low. Writes are ignored while `en_i` is high.
- R8: The effective high count is the stored high count, but never below 6. The effective low count is the stored low count, but never below 8.
- R9: `fall_o` pulses for one cycle in the first cycle of each low phase. `rise_o` pulses for one cycle in the first cycle of each high phase. The two never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; count writes are accepted only while low |
| mode_i | input | 3 | Speed field: 4 = fast, other = standard |
| cfg_we_i | input | 1 | Count register write strobe |
| cfg_sel_i | input | 2 | Count register select |
| cfg_data_i | input | CW (16) | Count value to write |
| scl_i | input | 1 | Sampled level of the clock line |
| scl_oe_o | output | 1 | Pull-low enable for the open-drain clock line |
| hold_o | output | 1 | Start-hold interval active |
| fall_o | output | 1 | Falling-edge strobe |
| rise_o | output | 1 | Rising-edge strobe |

## Verification
The bench models the wired-AND line with a target that can stretch the clock. A design that counts the high phase from its own release, instead of from the sampled line, would shorten the stretched high time.

Counts below the minimums are programmed to catch a missing clamp, which would produce phases far shorter than the minimum. A write while running checks that the following periods keep their old length. Disabling mid-phase checks that the line is released in the next cycle rather than at the end of the phase.

Speed values other than 2 and 4 are applied to show that only the value 4 selects fast timing.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  typedef enum logic [2:0] {PH_OFF, PH_HOLD, PH_LOW, PH_WAIT, PH_HIGH} phase_e;
  typedef enum logic [1:0] {SEL_STD_HI, SEL_STD_LO, SEL_FAST_HI, SEL_FAST_LO} sel_e;
  localparam logic [2:0] MODE_FAST = 3'd4;
  localparam int HI_OFS = 3;
  localparam int LO_OFS = 1;
  localparam int HI_MIN = 6;
  localparam int LO_MIN = 8;
  localparam int NREG   = 4;
endpackage

// File: rtl/i2c_scl_cfg.sv
module i2c_scl_cfg #(
  parameter int CW     = 16,
  parameter int STD_HI = 40,
  parameter int STD_LO = 47,
  parameter int FST_HI = 6,
  parameter int FST_LO = 13
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 we_i,
  input  logic [1:0]           sel_i,
  input  logic [CW-1:0]        data_i,
  output logic [3:0][CW-1:0]   cnt_o
);
  import i2c_scl_pkg::*;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int RV = (g == 0) ? STD_HI : (g == 1) ? STD_LO :
                        (g == 2) ? FST_HI : FST_LO;
    logic [CW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= CW'(RV);
      else if (we_i && !en_i && sel_i == 2'(g)) q <= data_i;
    end
    assign cnt_o[g] = q;
  end
endmodule

// File: rtl/i2c_scl_sel.sv
module i2c_scl_sel #(
  parameter int CW = 16
) (
  input  logic [2:0]         mode_i,
  input  logic [3:0][CW-1:0] cnt_i,
  output logic [CW-1:0]      hi_o,
  output logic [CW-1:0]      lo_o
);
  import i2c_scl_pkg::*;

  logic          fast;
  logic [CW-1:0] hi_raw, lo_raw;

  always_comb begin
    fast   = (mode_i == MODE_FAST);
    hi_raw = fast ? cnt_i[SEL_FAST_HI] : cnt_i[SEL_STD_HI];
    lo_raw = fast ? cnt_i[SEL_FAST_LO] : cnt_i[SEL_STD_LO];
    hi_o   = (hi_raw < CW'(HI_MIN)) ? CW'(HI_MIN) : hi_raw;
    lo_o   = (lo_raw < CW'(LO_MIN)) ? CW'(LO_MIN) : lo_raw;
  end
endmodule

// File: rtl/i2c_scl_phase.sv
module i2c_scl_phase #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          scl_i,
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] lo_i,
  output logic          scl_oe_o,
  output logic          hold_o,
  output logic          fall_o,
  output logic          rise_o
);
  import i2c_scl_pkg::*;

  localparam int CNTW = CW + 1;

  phase_e          ph_q;
  logic [CNTW-1:0] cnt_q;
  logic            first_q;
  logic [CNTW-1:0] hi_load, lo_load;

  // down-count loads: phase length = value + 1
  assign hi_load = CNTW'(hi_i) + CNTW'(HI_OFS - 1);
  assign lo_load = CNTW'(lo_i) + CNTW'(LO_OFS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_OFF;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      first_q <= 1'b0;
      if (!en_i) begin
        ph_q <= PH_OFF;
      end else begin
        case (ph_q)
          PH_OFF: begin
            ph_q    <= PH_HOLD;
            cnt_q   <= hi_load;
            first_q <= 1'b1;
          end
          PH_HOLD, PH_HIGH: begin
            if (cnt_q == '0) begin
              ph_q    <= PH_LOW;
              cnt_q   <= lo_load;
              first_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          PH_LOW: begin
            if (cnt_q == '0) ph_q <= PH_WAIT;
            else             cnt_q <= cnt_q - 1'b1;
          end
          PH_WAIT: begin
            // high count runs only once the line is seen released
            if (scl_i) begin
              ph_q    <= PH_HIGH;
              cnt_q   <= hi_load;
              first_q <= 1'b1;
            end
          end
          default: ph_q <= PH_OFF;
        endcase
      end
    end
  end

  assign scl_oe_o = (ph_q == PH_LOW);
  assign hold_o   = (ph_q == PH_HOLD);
  assign fall_o   = scl_oe_o && first_q;
  assign rise_o   = (ph_q == PH_HIGH) && first_q;
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int CW     = 16,
  parameter int STD_HI = 40,
  parameter int STD_LO = 47,
  parameter int FST_HI = 6,
  parameter int FST_LO = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [2:0]    mode_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [CW-1:0] cfg_data_i,
  input  logic          scl_i,
  output logic          scl_oe_o,
  output logic          hold_o,
  output logic          fall_o,
  output logic          rise_o
);
  logic [3:0][CW-1:0] cnt;
  logic [CW-1:0]      hi_eff, lo_eff;

  i2c_scl_cfg #(
    .CW(CW), .STD_HI(STD_HI), .STD_LO(STD_LO), .FST_HI(FST_HI), .FST_LO(FST_LO)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .data_i (cfg_data_i),
    .cnt_o  (cnt)
  );

  i2c_scl_sel #(.CW(CW)) u_sel (
    .mode_i (mode_i),
    .cnt_i  (cnt),
    .hi_o   (hi_eff),
    .lo_o   (lo_eff)
  );

  i2c_scl_phase #(.CW(CW)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .scl_i    (scl_i),
    .hi_i     (hi_eff),
    .lo_i     (lo_eff),
    .scl_oe_o (scl_oe_o),
    .hold_o   (hold_o),
    .fall_o   (fall_o),
    .rise_o   (rise_o)
  );
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic scl_i,
  input logic scl_oe_o,
  input logic hold_o,
  input logic fall_o,
  input logic rise_o
);
  // R6
  hold_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !scl_oe_o);

  // R2
  disable_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_oe_o && !hold_o && !fall_o && !rise_o));

  // R9
  fall_on_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> fall_o);

  // R9
  fall_only_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (scl_oe_o && !$past(scl_oe_o)));

  // R4
  rise_after_seen_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (!scl_oe_o && $past(scl_i)));

  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fall_o && rise_o));
endmodule

bind i2c_scl_gen i2c_scl_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .scl_i    (scl_i),
  .scl_oe_o (scl_oe_o),
  .hold_o   (hold_o),
  .fall_o   (fall_o),
  .rise_o   (rise_o)
);

// File: tb/test_i2c_scl_gen.sv
module test_i2c_scl_gen;
  localparam int CW = 16;
  localparam time TCLK = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [2:0]    mode = 3'd2;
  logic          we = 1'b0;
  logic [1:0]    sel = 2'd0;
  logic [CW-1:0] wdata = '0;
  logic          stretch = 1'b0;
  logic          scl_line;
  logic          scl_oe, hold, fall, rise;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  string tag  = "R1";

  always #(TCLK/2) clk = ~clk;

  // wired-AND line: released only if neither side pulls low
  assign scl_line = !scl_oe && !stretch;

  i2c_scl_gen #(.CW(CW)) i_i2c_scl_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_data_i(wdata), .scl_i(scl_line),
    .scl_oe_o(scl_oe), .hold_o(hold), .fall_o(fall), .rise_o(rise)
  );

  // ---------------- reference model ----------------
  int regs[4];
  int m_ph;   // 0 off, 1 hold, 2 low, 3 wait, 4 high
  int m_el;   // cycles elapsed in phase
  int m_len;  // phase length

  function automatic int eff_hi();
    int v = (mode == 3'd4) ? regs[2] : regs[0];
    return (v < 6) ? 6 : v;
  endfunction
  function automatic int eff_lo();
    int v = (mode == 3'd4) ? regs[3] : regs[1];
    return (v < 8) ? 8 : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs[0] = 40; regs[1] = 47; regs[2] = 6; regs[3] = 13;
      m_ph = 0; m_el = 0; m_len = 0;
    end else begin
      if (!en) m_ph = 0;
      else begin
        case (m_ph)
          0: begin m_ph = 1; m_el = 0; m_len = eff_hi() + 3; end
          1, 4: if (m_el + 1 == m_len) begin m_ph = 2; m_el = 0; m_len = eff_lo() + 1; end
                else m_el++;
          2: if (m_el + 1 == m_len) m_ph = 3; else m_el++;
          3: if (scl_line) begin m_ph = 4; m_el = 0; m_len = eff_hi() + 3; end
          default: m_ph = 0;
        endcase
      end
      if (we && !en) regs[sel] = int'(wdata);
    end
  end

  task automatic check(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    check("scl_oe", int'(scl_oe), int'(m_ph == 2));
    check("hold",   int'(hold),   int'(m_ph == 1));
    check("fall",   int'(fall),   int'(m_ph == 2 && m_el == 0));
    check("rise",   int'(rise),   int'(m_ph == 4 && m_el == 0));
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int s, int v);
    @(negedge clk);
    we = 1'b1; sel = 2'(s); wdata = CW'(v);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(TCLK * 100000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    tag = "R1";
    run(3);
    rst_n = 1'b1;
    run(2);
    // R7 program counts while disabled; R8 fast pair below minimum
    tag = "R7";
    wr(0, 10); wr(1, 12); wr(2, 2); wr(3, 3);
    // R3 R6 standard run from enable
    tag = "R3 R6";
    @(negedge clk); en = 1'b1;
    run(80);
    // R4 target stretches the high phase
    tag = "R4";
    while (!scl_oe) @(negedge clk);
    while (scl_oe) @(negedge clk);
    stretch = 1'b1;
    run(7);
    stretch = 1'b0;
    run(40);
    // R7 write while enabled is ignored
    tag = "R7";
    @(negedge clk); we = 1'b1; sel = 2'd1; wdata = 16'd30;
    @(negedge clk); we = 1'b0;
    run(60);
    // R5 R8 fast mode with clamped counts
    tag = "R5 R8";
    mode = 3'd4;
    run(60);
    // R5 other code falls back to standard
    tag = "R5";
    mode = 3'd3;
    run(40);
    // R2 disable in the middle of a low phase
    tag = "R2";
    while (!scl_oe) @(negedge clk);
    run(2);
    en = 1'b0;
    run(10);
    // R8 R6 zero high count clamped, fresh start hold
    tag = "R8 R6";
    mode = 3'd2;
    wr(0, 0);
    @(negedge clk); en = 1'b1;
    run(60);
    tag = "R2";
    en = 1'b0;
    run(5);
    finish_run();
  end
endmodule